// File: doc/BRIEF.md
# GCM Counter and Tag Sequencer

This block runs the counter-mode half of Galois/Counter Mode around an external block cipher and an external GHASH unit. At the start of a run it forms the initial counter block Y0, either by appending a 32-bit value of one to a 96-bit IV or by taking an already hashed IV from an input port. It then asks the cipher for one keystream block per data block, starting at Y1, and XORs each keystream block with the incoming data. It forwards the ciphertext of each block to the hash path. At the end of a run it can encrypt Y0 and XOR the result with the final GHASH value to form the tag. In verify mode it then compares that tag against a received tag.

A message may be split over several runs. The current Y0 and the low counter word are always visible on context outputs. A later run started without the new-message flag reloads both from context inputs. This lets the tag be computed and checked in a separate run after all data has passed.

The controller is a seven-state machine:
- IDLE: waits for `start`. It moves to KS_REQ when data blocks are requested. With no data blocks it moves to TAG_REQ if a tag is requested, otherwise to DONE.
- KS_REQ: holds a cipher request for the next counter block and moves to XOR on `aes_ack`.
- XOR: accepts one data block. It returns to KS_REQ while blocks remain. After the last block it moves to TAG_REQ or DONE.
- TAG_REQ: requests the encryption of Y0 and moves to TAG_WAIT on acknowledge.
- TAG_WAIT: waits for `ghash_valid`. It moves to CMP in verify mode, otherwise to DONE.
- CMP: compares one lane per cycle for a fixed number of cycles, then moves to DONE.
- DONE: pulses `done` for one cycle and returns to IDLE.

Top module: `gcm_ctr_tag`

## Requirements
- R1: With `init_msg`=1 and `iv_is96`=1, Y0 is `{iv_in, 31 zero bits, 1}`, and `ctx_y0_out` shows it from the cycle after `start`.
- R2: With `init_msg`=1 and `iv_is96`=0, Y0 is taken unchanged from `y0_hashed`.
- R3: The first keystream request of a new message carries Y1, which is Y0 with its low 32 bits plus one. Y0 is never used for data.
- R4: Each further keystream request adds one to the low 32 bits modulo 2^32, and the upper 96 bits equal those of Y0. `ctx_ctr_out` holds the low word of the last counter block used.
- R5: `dout` = `din` XOR keystream. `hash_blk` equals `dout` when encrypting (`decrypt`=0) and equals `din` when decrypting.
- R6: When `final_tag`=1, the run ends with a cipher request carrying Y0, and `tag_out` = E(Y0) XOR `ghash_sum`. `tag_valid` pulses with `done`.
- R7: With `verify_en`=1, `tag_ok` is 1 during `done` exactly when `tag_out` equals `rx_tag`; it is 0 whenever verify is off. The time from tag acknowledge to `done` does not depend on where a mismatch lies.
- R8: With `init_msg`=0, Y0 and the counter word are loaded from `ctx_y0_in` and `ctx_ctr_in`. With `final_tag`=0 the run ends after its data blocks, with no tag request and no `tag_valid`.
- R9: A run with `init_msg`=0, `final_tag`=1 and zero blocks computes and verifies the tag over the restored Y0.
- R10: After reset, `busy`, `aes_req`, `din_ready` and `dout_valid` are 0.
- R11: `start` is ignored while a run is in progress; Y0 and the data results are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (sampled in IDLE) |
| init_msg | input | 1 | 1: new message, build Y0; 0: restore context |
| final_tag | input | 1 | End the run with tag generation |
| verify_en | input | 1 | Compare the tag against rx_tag |
| decrypt | input | 1 | Direction; selects the hash-path source |
| iv_is96 | input | 1 | IV is 96 bits (else use y0_hashed) |
| iv_in | input | 96 | 96-bit IV |
| y0_hashed | input | 128 | GHASH of a non-96-bit IV |
| ctx_y0_in | input | 128 | Restored Y0 |
| ctx_ctr_in | input | 32 | Restored counter low word |
| num_blocks | input | 16 | Data blocks in this run |
| din | input | 128 | Data block in |
| din_valid | input | 1 | din is valid |
| din_ready | output | 1 | Block accepted this cycle when valid |
| dout | output | 128 | Data block out |
| dout_valid | output | 1 | dout is valid |
| hash_blk | output | 128 | Ciphertext block to the GHASH unit |
| hash_valid | output | 1 | hash_blk is valid |
| aes_req | output | 1 | Cipher request, held until acknowledge |
| aes_blk | output | 128 | Block to encrypt |
| aes_ack | input | 1 | Cipher result valid |
| aes_res | input | 128 | Cipher result |
| ghash_sum | input | 128 | Final GHASH value |
| ghash_valid | input | 1 | ghash_sum is valid |
| rx_tag | input | 128 | Received tag |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (one cycle) |
| tag_out | output | 128 | Computed tag |
| tag_valid | output | 1 | Tag produced in this run |
| tag_ok | output | 1 | Verification passed |
| ctx_y0_out | output | 128 | Current Y0 for saving |
| ctx_ctr_out | output | 32 | Current counter low word for saving |

## Verification
On every cycle, the assertions check several properties: the quiet outputs while idle, that a cipher request is held steady until acknowledged, that the counter steps by exactly one with its upper bits frozen, that Y0 cannot change during a run, and that the comparator walks its lanes in order. Only the bench's scenarios can show the values themselves. These are the two forms of Y0, the first counter being Y1, the wrap of the low word, the data and hash-path XOR in both directions, the tag value, restored-context runs, and that mismatches in the first and last lanes take the same number of cycles.

// File: rtl/gcm_ctr_tag_pkg.sv
package gcm_ctr_tag_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KS_REQ,
        ST_XOR,
        ST_TAG_REQ,
        ST_TAG_WAIT,
        ST_CMP,
        ST_DONE
    } gct_state_t;
endpackage

// File: rtl/gcm_ctr_reg.sv
module gcm_ctr_reg #(
    parameter int BLK_W = 128,
    parameter int CTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BLK_W-1:0] load_y0,
    input  logic [CTR_W-1:0] load_ctr,
    input  logic             bump,
    output logic [BLK_W-1:0] y0,
    output logic [CTR_W-1:0] ctr,
    output logic [BLK_W-1:0] next_blk
);
    localparam logic [CTR_W-1:0] ONE = CTR_W'(1);

    logic [BLK_W-1:0] y0_q;
    logic [CTR_W-1:0] ctr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y0_q  <= '0;
            ctr_q <= '0;
        end else if (load) begin
            y0_q  <= load_y0;
            ctr_q <= load_ctr;
        end else if (bump) begin
            ctr_q <= ctr_q + ONE;
        end
    end

    assign y0       = y0_q;
    assign ctr      = ctr_q;
    assign next_blk = {y0_q[BLK_W-1:CTR_W], ctr_q + ONE};

    AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bump && !load) |=> ctr_q == $past(ctr_q) + ONE); // R4
    AST_Y0_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(y0_q)); // R4
endmodule

// File: rtl/gcm_tag_cmp.sv
module gcm_tag_cmp #(
    parameter int W      = 128,
    parameter int LANE_W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         last,
    output logic         mismatch
);
    localparam int NL = W / LANE_W;
    localparam int IW = (NL > 1) ? $clog2(NL) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(NL - 1);
    localparam logic [IW-1:0] ONE      = IW'(1);

    logic [LANE_W-1:0] lane_x [NL];
    logic [IW-1:0]     idx_q;
    logic [LANE_W-1:0] diff_q;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        assign lane_x[i] = a[i*LANE_W +: LANE_W] ^ b[i*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            diff_q <= '0;
        end else if (clr) begin
            idx_q  <= '0;
            diff_q <= '0;
        end else if (en) begin
            idx_q  <= (idx_q == LAST_IDX) ? '0 : idx_q + ONE;
            diff_q <= diff_q | lane_x[idx_q];
        end
    end

    assign last     = en && (idx_q == LAST_IDX);
    assign mismatch = |diff_q;

    AST_CMP_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && idx_q != LAST_IDX) |=> idx_q == $past(idx_q) + ONE); // R7
endmodule

// File: rtl/gcm_ctr_tag.sv
module gcm_ctr_tag
    import gcm_ctr_tag_pkg::*;
#(
    parameter int BLK_W  = 128,
    parameter int CTR_W  = 32,
    parameter int LANE_W = 32,
    parameter int NBLK_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   init_msg,
    input  logic                   final_tag,
    input  logic                   verify_en,
    input  logic                   decrypt,
    input  logic                   iv_is96,
    input  logic [BLK_W-CTR_W-1:0] iv_in,
    input  logic [BLK_W-1:0]       y0_hashed,
    input  logic [BLK_W-1:0]       ctx_y0_in,
    input  logic [CTR_W-1:0]       ctx_ctr_in,
    input  logic [NBLK_W-1:0]      num_blocks,
    input  logic [BLK_W-1:0]       din,
    input  logic                   din_valid,
    output logic                   din_ready,
    output logic [BLK_W-1:0]       dout,
    output logic                   dout_valid,
    output logic [BLK_W-1:0]       hash_blk,
    output logic                   hash_valid,
    output logic                   aes_req,
    output logic [BLK_W-1:0]       aes_blk,
    input  logic                   aes_ack,
    input  logic [BLK_W-1:0]       aes_res,
    input  logic [BLK_W-1:0]       ghash_sum,
    input  logic                   ghash_valid,
    input  logic [BLK_W-1:0]       rx_tag,
    output logic                   busy,
    output logic                   done,
    output logic [BLK_W-1:0]       tag_out,
    output logic                   tag_valid,
    output logic                   tag_ok,
    output logic [BLK_W-1:0]       ctx_y0_out,
    output logic [CTR_W-1:0]       ctx_ctr_out
);
    localparam logic [NBLK_W-1:0] REM_ONE = NBLK_W'(1);

    gct_state_t        state_q, state_d;
    logic [NBLK_W-1:0] rem_q;
    logic              final_q, verify_q, decrypt_q;
    logic [BLK_W-1:0]  ks_q, ek0_q, tag_q;

    logic              go, ld, bump, xfer;
    logic [BLK_W-1:0]  y0_new, y0_cur, next_blk;
    logic [CTR_W-1:0]  ctr_new, ctr_cur;
    logic              cmp_clr, cmp_en, cmp_last, cmp_bad;

    assign go      = (state_q == ST_IDLE) && start;
    assign ld      = go;
    assign y0_new  = !init_msg ? ctx_y0_in :
                     iv_is96   ? {iv_in, {(CTR_W-1){1'b0}}, 1'b1} : y0_hashed;
    assign ctr_new = init_msg ? y0_new[CTR_W-1:0] : ctx_ctr_in;
    assign bump    = (state_q == ST_KS_REQ) && aes_ack;
    assign xfer    = (state_q == ST_XOR) && din_valid;
    assign cmp_clr = (state_q == ST_TAG_WAIT) && ghash_valid;
    assign cmp_en  = (state_q == ST_CMP);

    gcm_ctr_reg #(.BLK_W(BLK_W), .CTR_W(CTR_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_y0(y0_new),
        .load_ctr(ctr_new), .bump(bump), .y0(y0_cur), .ctr(ctr_cur),
        .next_blk(next_blk)
    );

    gcm_tag_cmp #(.W(BLK_W), .LANE_W(LANE_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .clr(cmp_clr), .en(cmp_en),
        .a(tag_q), .b(rx_tag), .last(cmp_last), .mismatch(cmp_bad)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = (num_blocks != '0) ? ST_KS_REQ :
                                              final_tag ? ST_TAG_REQ : ST_DONE;
            ST_KS_REQ:   if (aes_ack) state_d = ST_XOR;
            ST_XOR:      if (din_valid) state_d = (rem_q != REM_ONE) ? ST_KS_REQ :
                                                  final_q ? ST_TAG_REQ : ST_DONE;
            ST_TAG_REQ:  if (aes_ack) state_d = ST_TAG_WAIT;
            ST_TAG_WAIT: if (ghash_valid) state_d = verify_q ? ST_CMP : ST_DONE;
            ST_CMP:      if (cmp_last) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // run data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q     <= '0;
            final_q   <= 1'b0;
            verify_q  <= 1'b0;
            decrypt_q <= 1'b0;
            ks_q      <= '0;
            ek0_q     <= '0;
            tag_q     <= '0;
        end else begin
            if (go) begin
                rem_q     <= num_blocks;
                final_q   <= final_tag;
                verify_q  <= verify_en;
                decrypt_q <= decrypt;
            end
            if (bump) ks_q <= aes_res;
            if (xfer) rem_q <= rem_q - REM_ONE;
            if ((state_q == ST_TAG_REQ) && aes_ack) ek0_q <= aes_res;
            if (cmp_clr) tag_q <= ek0_q ^ ghash_sum;
        end
    end

    // outputs
    always_comb begin
        din_ready  = 1'b0;
        dout_valid = 1'b0;
        aes_req    = 1'b0;
        aes_blk    = next_blk;
        done       = 1'b0;
        tag_valid  = 1'b0;
        tag_ok     = 1'b0;
        unique case (state_q)
            ST_KS_REQ:  aes_req = 1'b1;
            ST_XOR: begin
                din_ready  = 1'b1;
                dout_valid = din_valid;
            end
            ST_TAG_REQ: begin
                aes_req = 1'b1;
                aes_blk = y0_cur;
            end
            ST_DONE: begin
                done      = 1'b1;
                tag_valid = final_q;
                tag_ok    = final_q && verify_q && !cmp_bad;
            end
            default: ;
        endcase
    end

    assign dout        = din ^ ks_q;
    assign hash_blk    = decrypt_q ? din : dout;
    assign hash_valid  = dout_valid;
    assign busy        = (state_q != ST_IDLE);
    assign tag_out     = tag_q;
    assign ctx_y0_out  = y0_cur;
    assign ctx_ctr_out = ctr_cur;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !aes_req && !din_ready && !dout_valid); // R10
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (aes_req && !aes_ack) |=> aes_req && $stable(aes_blk)); // R3
    AST_DATA_NOT_Y0: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> ctr_cur != y0_cur[CTR_W-1:0] || !final_q); // R3
    AST_RUN_KEEPS_Y0: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(ctx_y0_out)); // R11
endmodule

// File: tb/gcm_ctr_tag_test.sv
module gcm_ctr_tag_test;
    logic clk = 0, rst_n = 0;
    always #5 clk = ~clk;

    logic start = 0, init_msg = 0, final_tag = 0, verify_en = 0, decrypt = 0, iv_is96 = 0;
    logic [95:0]  iv_in = '0;
    logic [127:0] y0_hashed = '0, ctx_y0_in = '0, din = '0, aes_res = '0, ghash_sum = '0, rx_tag = '0;
    logic [31:0]  ctx_ctr_in = '0;
    logic [15:0]  num_blocks = '0;
    logic din_valid = 0, aes_ack = 0, ghash_valid = 1;
    logic din_ready, dout_valid, hash_valid, aes_req, busy, done, tag_valid, tag_ok;
    logic [127:0] dout, hash_blk, aes_blk, tag_out, ctx_y0_out;
    logic [31:0]  ctx_ctr_out;

    gcm_ctr_tag uut (.*);

    int checks = 0, errors = 0, cyc = 0, ack_cyc = 0, done_cyc = 0;
    logic [127:0] exp_out_q[$], exp_hash_q[$], req_log[$];
    logic got_tv, got_ok;
    logic [127:0] got_tag;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [127:0] ecb(input logic [127:0] x);
        return {x[63:0], x[127:64]} ^ {x[126:0], x[127]} ^ 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // cipher model
    initial forever begin
        @(negedge clk);
        if (aes_req) begin
            req_log.push_back(aes_blk);
            @(posedge clk); #1;
            aes_ack = 1; aes_res = ecb(aes_blk);
            @(posedge clk); #1;
            aes_ack = 0; ack_cyc = cyc;
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (dout_valid) begin
            if (exp_out_q.size() == 0) chk(0, "R5 unexpected", dout, '0);
            else begin
                logic [127:0] eo, eh;
                eo = exp_out_q.pop_front();
                eh = exp_hash_q.pop_front();
                chk(dout === eo, "R5 dout", dout, eo);
                chk(hash_blk === eh && hash_valid, "R5 hash_blk", hash_blk, eh);
            end
        end
    end

    task automatic run(input bit ini, fin, ver, dec, i96, input logic [95:0] iv,
                       input logic [127:0] hy, cy, input logic [31:0] cc, input int n,
                       input logic [127:0] gh, rx, input bit poke);
        logic [127:0] y0e, d;
        logic [31:0] c;
        y0e = !ini ? cy : (i96 ? {iv, 32'h1} : hy);
        c   = ini ? y0e[31:0] : cc;
        req_log.delete();
        @(posedge clk); #1;
        init_msg = ini; final_tag = fin; verify_en = ver; decrypt = dec; iv_is96 = i96;
        iv_in = iv; y0_hashed = hy; ctx_y0_in = cy; ctx_ctr_in = cc; num_blocks = 16'(n);
        ghash_sum = gh; rx_tag = rx; start = 1;
        @(posedge clk); #1;
        start = 0;
        for (int b = 0; b < n; b++) begin
            d = {4{32'(b) * 32'h9E3779B9 + cc + 32'h1234}};
            c = c + 32'h1;
            exp_out_q.push_back(d ^ ecb({y0e[127:32], c}));
            exp_hash_q.push_back(dec ? d : (d ^ ecb({y0e[127:32], c})));
            din = d; din_valid = 1;
            forever begin
                @(negedge clk);
                if (din_ready) begin @(posedge clk); #1; break; end
            end
            din_valid = 0;
            if (poke && b == 0) begin
                start = 1; init_msg = 1; iv_is96 = 1; iv_in = ~iv;
                @(posedge clk); #1; start = 0;
            end
        end
        forever begin
            @(negedge clk);
            if (done) break;
        end
        done_cyc = cyc; got_tv = tag_valid; got_ok = tag_ok; got_tag = tag_out;
    endtask

    initial begin
        #1500000;
        chk(0, "watchdog", '0, '0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [95:0] iv;
        logic [127:0] hy, gh, sy0, tg, cy;
        logic [31:0] sctr;
        int d0, d1;
        iv = 96'hCAFEBABE_DEADBEEF_01234567;
        gh = 128'h11112222_33334444_55556666_77778888;
        repeat (3) @(posedge clk);
        #1;
        chk(!busy && !aes_req && !din_ready && !dout_valid, "R10 reset", {busy, aes_req, din_ready, dout_valid}, '0);
        rst_n = 1;

        // encrypt, 96-bit IV, tag without verify
        run(1, 1, 0, 0, 1, iv, '0, '0, '0, 3, gh, '0, 0);
        chk(ctx_y0_out === {iv, 32'h1}, "R1 Y0", ctx_y0_out, {iv, 32'h1});
        chk(req_log[0] === {iv, 32'h2}, "R3 first counter", req_log[0], {iv, 32'h2});
        chk(req_log[3] === {iv, 32'h1}, "R6 tag request", req_log[3], {iv, 32'h1});
        chk(got_tv && got_tag === (ecb({iv, 32'h1}) ^ gh), "R6 tag", got_tag, ecb({iv, 32'h1}) ^ gh);
        chk(!got_ok, "R7 no verify", {127'b0, got_ok}, '0);

        // hashed Y0, decrypt, counter wrap, no tag
        hy = 128'h89ABCDEF_01234567_76543210_FFFFFFFE;
        run(1, 0, 0, 1, 0, iv, hy, '0, '0, 3, gh, '0, 0);
        chk(ctx_y0_out === hy, "R2 hashed Y0", ctx_y0_out, hy);
        chk(req_log[2] === {hy[127:32], 32'h1}, "R4 wrap", req_log[2], {hy[127:32], 32'h1});
        chk(ctx_ctr_out === 32'h1, "R4 ctx counter", 128'(ctx_ctr_out), 128'h1);
        chk(!got_tv && req_log.size() == 3, "R8 no tag", 128'(req_log.size()), 128'd3);
        sy0 = ctx_y0_out; sctr = ctx_ctr_out;

        // separate tag-only run with verify, match
        tg = ecb(sy0) ^ gh;
        run(0, 1, 1, 1, 0, '0, '0, sy0, sctr, 0, gh, tg, 0);
        chk(req_log.size() == 1 && req_log[0] === sy0, "R9 restored Y0", req_log[0], sy0);
        chk(got_tv && got_ok && got_tag === tg, "R9 tag pass", got_tag, tg);

        // mismatch in lowest lane, then in highest lane
        run(0, 1, 1, 1, 0, '0, '0, sy0, sctr, 0, gh, tg ^ 128'h1, 0);
        d0 = done_cyc - ack_cyc;
        chk(!got_ok && got_tv, "R7 low mismatch", {127'b0, got_ok}, '0);
        run(0, 1, 1, 1, 0, '0, '0, sy0, sctr, 0, gh, tg ^ {1'b1, 127'b0}, 0);
        d1 = done_cyc - ack_cyc;
        chk(!got_ok, "R7 high mismatch", {127'b0, got_ok}, '0);
        chk(d0 == d1, "R7 fixed timing", 128'(d1), 128'(d0));

        // restored context with data, start poked mid-run
        cy = 128'hA5A5A5A5_5A5A5A5A_C3C3C3C3_3C3C3C3C;
        run(0, 0, 0, 0, 0, iv, '0, cy, 32'd5, 2, gh, '0, 1);
        chk(req_log[0] === {cy[127:32], 32'd6}, "R8 restored counter", req_log[0], {cy[127:32], 32'd6});
        chk(ctx_y0_out === cy, "R11 start ignored", ctx_y0_out, cy);
        chk(ctx_ctr_out === 32'd7, "R11 counter", 128'(ctx_ctr_out), 128'd7);
        chk(exp_out_q.size() == 0, "R5 all blocks seen", 128'(exp_out_q.size()), '0);

        repeat (3) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule